// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Victim Buffer

This block is a level-one data cache with a single way per set, paired with a small fully associative side buffer. The side buffer holds lines recently pushed out of the primary array. A processor-side port carries one request at a time, either a read or a write of one line-sized word. A next-level port issues single-line reads and write-backs to a fixed-latency memory.

A request that hits the primary array is answered one cycle after it is accepted. On a primary miss the side buffer is searched before any next-level traffic is issued. If the line is in the side buffer, it is swapped with the resident primary line and the request is answered two cycles after acceptance. This gives the sets that conflict most an extra way or two without touching the next level. If the line misses in both structures, the displaced primary line moves into the side buffer and one next-level read fetches the requested line. When the side buffer is full, its oldest entry makes room, and that entry is written back first if it is dirty.

Top module: `vc_l1_cache`

## Requirements
- R1: After reset `cpu_ready` is 1, `cpu_resp_valid` and `mem_req_valid` are 0, and every primary and side-buffer entry is empty, so the first access to any address goes to the next level.
- R2: The primary array is direct-mapped. The set index is the low `INDEX_W` bits of `cpu_req_addr` and the tag is the remaining high bits. Two addresses with the same index displace each other, and addresses with different indices can both be resident.
- R3: A primary hit is answered with `cpu_resp_valid` in the cycle after acceptance, and it issues no next-level request.
- R4: On a primary miss the side buffer is searched first. A side-buffer hit is answered two cycles after acceptance and issues no next-level request.
- R5: On a side-buffer hit, the requested line moves into the primary slot and the displaced primary line takes over the same side-buffer entry. Each line keeps its own dirty state.
- R6: A miss in both structures issues exactly one next-level read (`mem_req_write`=0) for the requested address. The response arrives `MEM_LAT+3` cycles after acceptance when there is no write-back. A valid displaced primary line is placed in the side buffer.
- R7: The side buffer replaces entries in FIFO order, and its depth `VICT_N` is 4 or 8. If the entry about to be overwritten is dirty, it is first written to the next level (`mem_req_write`=1) with its own address and data. Such a miss is answered `2*MEM_LAT+4` cycles after acceptance.
- R8: Writes are write-back and write-allocate. A write hit sets the dirty bit and causes no next-level traffic. A write miss fetches the line and then overwrites it. A clean line that leaves the side buffer is dropped without a next-level write.
- R9: A given line address is held in at most one side-buffer entry, and every read returns the most recently written value for its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req_valid | input | 1 | Request strobe, accepted when `cpu_ready` is 1 |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Line address: tag in the high bits, index in the low `INDEX_W` bits |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Cache idle and able to accept a request |
| cpu_resp_valid | output | 1 | One-cycle pulse marking a completed request |
| cpu_resp_rdata | output | DATA_W | Line value after the request (written data for writes) |
| mem_req_valid | output | 1 | One-cycle next-level request strobe |
| mem_req_write | output | 1 | 1 = write-back, 0 = line read |
| mem_req_addr | output | ADDR_W | Next-level line address |
| mem_req_wdata | output | DATA_W | Write-back data |
| mem_resp_valid | input | 1 | Next-level completion (read data or write acknowledge) |
| mem_resp_rdata | input | DATA_W | Next-level read data |

## Verification
The bench drives one index through a conflict chain. It fills the side buffer until the oldest entry is a dirty line, then forces one more miss. A design that discarded that line without a write-back, or wrote back the wrong entry, would return stale data when the line is later re-read from memory. A design that skipped the swap, or issued a next-level read on a side-buffer hit, would show a six-cycle latency or an extra read where a two-cycle answer is expected. Clean evictions are checked for spurious write-backs. A write miss is checked to see that the fetched line is merged with the write and not returned raw.

// File: rtl/vc_pkg.sv
// Shared definitions for the victim-buffered data cache.
// Assumes one outstanding request at a time; states are ordered for readability only.
package vc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_VSRCH   = 3'd1,
        ST_WB_REQ  = 3'd2,
        ST_WB_WAIT = 3'd3,
        ST_RD_REQ  = 3'd4,
        ST_RD_WAIT = 3'd5
    } vc_state_e;
endpackage

// File: rtl/vc_primary.sv
// Direct-mapped line store: one tag, valid bit, dirty bit and data word per set.
// Read is combinational at idx; a write installs a valid line at the same idx.
// Assumes the controller never reads and writes different sets in one cycle.
module vc_primary #(
    parameter int ADDR_W  = 10,
    parameter int INDEX_W = 4,
    parameter int DATA_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [INDEX_W-1:0]        idx,
    output logic                      rd_valid,
    output logic                      rd_dirty,
    output logic [ADDR_W-INDEX_W-1:0] rd_tag,
    output logic [DATA_W-1:0]         rd_data,
    input  logic                      wr_en,
    input  logic [ADDR_W-INDEX_W-1:0] wr_tag,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic                      wr_dirty
);
    localparam int SETS  = 1 << INDEX_W;
    localparam int TAG_W = ADDR_W - INDEX_W;

    logic [SETS-1:0]   valid_q;
    logic [SETS-1:0]   dirty_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [DATA_W-1:0] data_q [SETS];

    // Status bits: cleared by reset, set on install.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (wr_en) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= wr_dirty;
        end
    end

    // Tag and data payload: no reset needed, guarded by valid.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[idx]  <= wr_tag;
            data_q[idx] <= wr_data;
        end
    end

    // Combinational read of the addressed set.
    always_comb begin
        rd_valid = valid_q[idx];
        rd_dirty = dirty_q[idx];
        rd_tag   = tag_q[idx];
        rd_data  = data_q[idx];
    end
endmodule

// File: rtl/vc_victim.sv
// Fully associative side buffer of VICT_N lines with full line addresses.
// Lookup is combinational; entries are replaced in FIFO order via an insert pointer
// that advances only on push. A swap rewrites the hit entry in place.
module vc_victim #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter int VICT_N = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         look_addr,
    output logic [VICT_N-1:0]         match,
    output logic                      hit,
    output logic [$clog2(VICT_N)-1:0] hit_idx,
    output logic                      hit_dirty,
    output logic [DATA_W-1:0]         hit_data,
    output logic [$clog2(VICT_N)-1:0] ptr,
    output logic                      old_valid,
    output logic                      old_dirty,
    output logic [ADDR_W-1:0]         old_addr,
    output logic [DATA_W-1:0]         old_data,
    input  logic                      wr_en,
    input  logic [$clog2(VICT_N)-1:0] wr_sel,
    input  logic                      wr_valid,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic                      wr_dirty,
    input  logic                      push
);
    localparam int PTR_W = $clog2(VICT_N);

    logic [VICT_N-1:0] valid_q;
    logic [VICT_N-1:0] dirty_q;
    logic [ADDR_W-1:0] addr_q [VICT_N];
    logic [DATA_W-1:0] data_q [VICT_N];

    // Entry state: reset clears valid/dirty; a write replaces one entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_sel] <= wr_valid;
            dirty_q[wr_sel] <= wr_valid & wr_dirty;
        end
    end

    // Entry payload written alongside the status bits.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            addr_q[wr_sel] <= wr_addr;
            data_q[wr_sel] <= wr_data;
        end
    end

    // FIFO insert pointer: advances once per push, wraps at the depth.
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr <= '0;
        else if (push) ptr <= ptr + PTR_W'(1);
    end

    // One comparator per entry.
    for (genvar g = 0; g < VICT_N; g++) begin : g_cmp
        assign match[g] = valid_q[g] && (addr_q[g] == look_addr);
    end

    // Encode the matching entry and select its fields.
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < VICT_N; i++) begin
            if (match[i]) hit_idx = PTR_W'(i);
        end
        hit       = |match;
        hit_dirty = dirty_q[hit_idx];
        hit_data  = data_q[hit_idx];
    end

    // Fields of the entry that the next push will overwrite.
    always_comb begin
        old_valid = valid_q[ptr];
        old_dirty = dirty_q[ptr];
        old_addr  = addr_q[ptr];
        old_data  = data_q[ptr];
    end
endmodule

// File: rtl/vc_l1_cache.sv
// Direct-mapped data cache with a FIFO-replaced victim buffer and a one-request
// next-level port. One processor request is in flight at a time. Primary hits answer
// in one cycle, victim hits in two, and misses wait on the next level. Next-level
// responses (read data or write ack) arrive as a single-cycle mem_resp_valid pulse.
module vc_l1_cache #(
    parameter int ADDR_W  = 10,
    parameter int INDEX_W = 4,
    parameter int DATA_W  = 32,
    parameter int VICT_N  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_ready,
    output logic              cpu_resp_valid,
    output logic [DATA_W-1:0] cpu_resp_rdata,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_resp_valid,
    input  logic [DATA_W-1:0] mem_resp_rdata
);
    import vc_pkg::*;

    localparam int TAG_W = ADDR_W - INDEX_W;
    localparam int PTR_W = $clog2(VICT_N);

    vc_state_e         state, next_state;
    logic              req_write_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic [DATA_W-1:0] req_wdata_q;

    logic [ADDR_W-1:0]  look_addr;
    logic [INDEX_W-1:0] look_idx;
    logic [TAG_W-1:0]   look_tag;
    logic               p_valid, p_dirty, prim_hit;
    logic [TAG_W-1:0]   p_tag;
    logic [DATA_W-1:0]  p_data;
    logic               pw_en, pw_dirty;
    logic [DATA_W-1:0]  pw_data;

    logic [VICT_N-1:0] vic_match;
    logic              vic_hit, vh_dirty, vic_old_valid, vic_old_dirty;
    logic [PTR_W-1:0]  vh_idx, vic_ptr, vw_sel;
    logic [DATA_W-1:0] vh_data, vic_old_data;
    logic [ADDR_W-1:0] vic_old_addr;
    logic              vw_en, vw_valid, vic_push;

    logic              resp_set;
    logic [DATA_W-1:0] resp_data;

    // Lookup address: the incoming request while idle, the held request otherwise.
    always_comb begin
        look_addr = (state == ST_IDLE) ? cpu_req_addr : req_addr_q;
        look_idx  = look_addr[INDEX_W-1:0];
        look_tag  = look_addr[ADDR_W-1:INDEX_W];
        prim_hit  = p_valid && (p_tag == look_tag);
    end

    vc_primary #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .DATA_W(DATA_W)) u_prim (
        .clk(clk), .rst_n(rst_n), .idx(look_idx),
        .rd_valid(p_valid), .rd_dirty(p_dirty), .rd_tag(p_tag), .rd_data(p_data),
        .wr_en(pw_en), .wr_tag(look_tag), .wr_data(pw_data), .wr_dirty(pw_dirty)
    );

    vc_victim #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VICT_N(VICT_N)) u_vic (
        .clk(clk), .rst_n(rst_n), .look_addr(req_addr_q),
        .match(vic_match), .hit(vic_hit), .hit_idx(vh_idx),
        .hit_dirty(vh_dirty), .hit_data(vh_data), .ptr(vic_ptr),
        .old_valid(vic_old_valid), .old_dirty(vic_old_dirty),
        .old_addr(vic_old_addr), .old_data(vic_old_data),
        .wr_en(vw_en), .wr_sel(vw_sel), .wr_valid(vw_valid),
        .wr_addr({p_tag, look_idx}), .wr_data(p_data), .wr_dirty(p_dirty),
        .push(vic_push)
    );

    // Controller: next state, array writes, next-level strobes and response.
    always_comb begin
        next_state    = state;
        pw_en         = 1'b0;
        pw_data       = req_wdata_q;
        pw_dirty      = 1'b0;
        vw_en         = 1'b0;
        vw_sel        = vic_ptr;
        vw_valid      = 1'b1;
        vic_push      = 1'b0;
        resp_set      = 1'b0;
        resp_data     = p_data;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = req_addr_q;
        mem_req_wdata = vic_old_data;
        unique case (state)
            ST_IDLE: if (cpu_req_valid) begin
                if (prim_hit) begin
                    resp_set = 1'b1;
                    if (cpu_req_write) begin
                        pw_en     = 1'b1;
                        pw_data   = cpu_req_wdata;
                        pw_dirty  = 1'b1;
                        resp_data = cpu_req_wdata;
                    end
                end else begin
                    next_state = ST_VSRCH;
                end
            end
            ST_VSRCH: if (vic_hit) begin
                pw_en      = 1'b1;
                pw_data    = req_write_q ? req_wdata_q : vh_data;
                pw_dirty   = vh_dirty | req_write_q;
                vw_en      = 1'b1;
                vw_sel     = vh_idx;
                vw_valid   = p_valid;
                resp_set   = 1'b1;
                resp_data  = pw_data;
                next_state = ST_IDLE;
            end else if (p_valid && vic_old_valid && vic_old_dirty) begin
                next_state = ST_WB_REQ;
            end else begin
                vw_en      = p_valid;
                vic_push   = p_valid;
                next_state = ST_RD_REQ;
            end
            ST_WB_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = vic_old_addr;
                next_state    = ST_WB_WAIT;
            end
            ST_WB_WAIT: if (mem_resp_valid) begin
                vw_en      = 1'b1;
                vic_push   = 1'b1;
                next_state = ST_RD_REQ;
            end
            ST_RD_REQ: begin
                mem_req_valid = 1'b1;
                next_state    = ST_RD_WAIT;
            end
            ST_RD_WAIT: if (mem_resp_valid) begin
                pw_en      = 1'b1;
                pw_data    = req_write_q ? req_wdata_q : mem_resp_rdata;
                pw_dirty   = req_write_q;
                resp_set   = 1'b1;
                resp_data  = pw_data;
                next_state = ST_IDLE;
            end
            default: next_state = ST_IDLE;
        endcase
    end

    // State register and capture of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            req_write_q <= 1'b0;
            req_addr_q  <= '0;
            req_wdata_q <= '0;
        end else begin
            state <= next_state;
            if (state == ST_IDLE && cpu_req_valid) begin
                req_write_q <= cpu_req_write;
                req_addr_q  <= cpu_req_addr;
                req_wdata_q <= cpu_req_wdata;
            end
        end
    end

    // Registered response pulse and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_resp_valid <= 1'b0;
            cpu_resp_rdata <= '0;
        end else begin
            cpu_resp_valid <= resp_set;
            if (resp_set) cpu_resp_rdata <= resp_data;
        end
    end

    assign cpu_ready = (state == ST_IDLE);
endmodule

// File: rtl/vc_l1_cache_chk.sv
// Protocol and ordering checks for vc_l1_cache, attached by bind.
// Assumes it sees the top's internal controller signals by name.
module vc_l1_cache_chk #(
    parameter int VICT_N = 4
) (
    input logic              clk,
    input logic              rst_n,
    input vc_pkg::vc_state_e state,
    input logic              cpu_req_valid,
    input logic              cpu_ready,
    input logic              cpu_resp_valid,
    input logic              prim_hit,
    input logic              vic_hit,
    input logic [VICT_N-1:0] vic_match,
    input logic              vic_push,
    input logic              vic_old_valid,
    input logic              vic_old_dirty,
    input logic              mem_req_valid,
    input logic              mem_resp_valid
);
    import vc_pkg::*;

    assert_hit_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && cpu_ready && prim_hit) |=> cpu_resp_valid);

    assert_idle_no_mem_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !mem_req_valid);

    assert_victim_hit_local_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_VSRCH && vic_hit) |=> (cpu_resp_valid && !mem_req_valid));

    assert_single_mem_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    assert_dirty_written_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vic_push && vic_old_valid && vic_old_dirty) |-> (state == ST_WB_WAIT && mem_resp_valid));

    assert_unique_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vic_match));
endmodule

bind vc_l1_cache vc_l1_cache_chk #(.VICT_N(VICT_N)) u_chk (.*);

// File: tb/tb_vc_l1_cache.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, next level modelled as fixed-latency memory.
module tb_vc_l1_cache;
    localparam int ADDR_W  = 10;
    localparam int INDEX_W = 4;
    localparam int DATA_W  = 32;
    localparam int MEM_LAT = 3;
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int LAT_HIT  = 1;
    localparam int LAT_VHIT = 2;
    localparam int LAT_MISS = MEM_LAT + 3;
    localparam int LAT_WB   = 2 * MEM_LAT + 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_req_valid = 1'b0;
    logic              cpu_req_write = 1'b0;
    logic [ADDR_W-1:0] cpu_req_addr = '0;
    logic [DATA_W-1:0] cpu_req_wdata = '0;
    logic              cpu_ready, cpu_resp_valid;
    logic [DATA_W-1:0] cpu_resp_rdata;
    logic              mem_req_valid, mem_req_write;
    logic [ADDR_W-1:0] mem_req_addr;
    logic [DATA_W-1:0] mem_req_wdata;
    logic              mem_resp_valid = 1'b0;
    logic [DATA_W-1:0] mem_resp_rdata = '0;

    logic [DATA_W-1:0] memarr [DEPTH];
    logic [DATA_W-1:0] gold   [DEPTH];
    int mem_reads = 0, mem_writes = 0;
    logic [ADDR_W-1:0] last_wr_addr = '0;
    logic [DATA_W-1:0] last_wr_data = '0;
    int checks = 0, errors = 0;
    logic [DATA_W-1:0] wdat_r1 = 32'hCAFE_0001;

    always #4 clk = ~clk;

    vc_l1_cache #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .DATA_W(DATA_W), .VICT_N(4)) dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
        .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
        .cpu_ready(cpu_ready), .cpu_resp_valid(cpu_resp_valid), .cpu_resp_rdata(cpu_resp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_resp_valid(mem_resp_valid), .mem_resp_rdata(mem_resp_rdata)
    );

    function automatic logic [DATA_W-1:0] init_val(logic [ADDR_W-1:0] a);
        return {6'h2A, a, 16'h5A5A};
    endfunction

    function automatic logic [ADDR_W-1:0] la(int t, int i);
        return ADDR_W'(t * (1 << INDEX_W) + i);
    endfunction

    task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Next-level model: a request seen at a falling edge is answered MEM_LAT cycles later.
    initial begin
        for (int i = 0; i < DEPTH; i++) memarr[i] = init_val(ADDR_W'(i));
        forever begin
            @(negedge clk);
            mem_resp_valid = 1'b0;
            if (mem_req_valid) begin
                if (mem_req_write) begin
                    mem_writes++;
                    last_wr_addr = mem_req_addr;
                    last_wr_data = mem_req_wdata;
                    memarr[mem_req_addr] = mem_req_wdata;
                end else begin
                    mem_reads++;
                    mem_resp_rdata = memarr[mem_req_addr];
                end
                repeat (MEM_LAT - 1) @(negedge clk);
                @(negedge clk);
                mem_resp_valid = 1'b1;
            end
        end
    end

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R1: actual=hung expected=finished");
        report();
    end

    // One processor access: returns the response data and latency in cycles.
    task automatic access(input logic wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                          output logic [DATA_W-1:0] rd, output int lat);
        while (!cpu_ready) @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_write = wr;
        cpu_req_addr  = a;
        cpu_req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        lat = 1;
        while (!cpu_resp_valid) begin
            @(negedge clk);
            lat++;
        end
        rd = cpu_resp_rdata;
        if (wr) gold[a] = wd;
    endtask

    // Access and check data, latency and next-level traffic.
    task automatic run(input string req, input logic wr, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] wd, input int exp_lat, input int dr, input int dw);
        logic [DATA_W-1:0] rd;
        int lat;
        int r0 = mem_reads;
        int w0 = mem_writes;
        access(wr, a, wd, rd, lat);
        chk({req, " data"}, rd, wr ? wd : gold[a]);
        chk({req, " latency"}, DATA_W'(lat), DATA_W'(exp_lat));
        chk({req, " reads"}, DATA_W'(mem_reads - r0), DATA_W'(dr));
        chk({req, " writes"}, DATA_W'(mem_writes - w0), DATA_W'(dw));
    endtask

    task automatic t_reset();
        chk("R1 ready", DATA_W'(cpu_ready), 1);
        chk("R1 resp idle", DATA_W'(cpu_resp_valid), 0);
        chk("R1 mem idle", DATA_W'(mem_req_valid), 0);
    endtask

    task automatic t_cold_and_hit();
        run("R1 R6 cold miss", 1'b0, la(1, 2), '0, LAT_MISS, 1, 0);
        run("R3 read hit", 1'b0, la(1, 2), '0, LAT_HIT, 0, 0);
        run("R8 write hit", 1'b1, la(1, 2), wdat_r1, LAT_HIT, 0, 0);
        run("R3 R9 reread", 1'b0, la(1, 2), '0, LAT_HIT, 0, 0);
    endtask

    task automatic t_conflict_swap();
        run("R2 conflict miss", 1'b0, la(2, 2), '0, LAT_MISS, 1, 0);
        run("R4 R5 victim hit dirty", 1'b0, la(1, 2), '0, LAT_VHIT, 0, 0);
        run("R5 R9 swapped back", 1'b0, la(2, 2), '0, LAT_VHIT, 0, 0);
    endtask

    task automatic t_fifo_writeback();
        run("R6 fill 3", 1'b0, la(3, 2), '0, LAT_MISS, 1, 0);
        run("R6 fill 4", 1'b0, la(4, 2), '0, LAT_MISS, 1, 0);
        run("R6 fill 5", 1'b0, la(5, 2), '0, LAT_MISS, 1, 0);
        run("R7 dirty oldest out", 1'b0, la(6, 2), '0, LAT_WB, 1, 1);
        chk("R7 wb addr", DATA_W'(last_wr_addr), DATA_W'(la(1, 2)));
        chk("R7 wb data", last_wr_data, wdat_r1);
        run("R7 R9 refetch written", 1'b0, la(1, 2), '0, LAT_MISS, 1, 0);
        run("R4 R7 fifo keeps newer", 1'b0, la(3, 2), '0, LAT_VHIT, 0, 0);
        run("R8 clean drop", 1'b0, la(2, 2), '0, LAT_MISS, 1, 0);
    endtask

    task automatic t_write_miss();
        run("R8 write allocate", 1'b1, la(7, 5), 32'h1234_5678, LAT_MISS, 1, 0);
        run("R8 merged line", 1'b0, la(7, 5), '0, LAT_HIT, 0, 0);
    endtask

    task automatic t_distinct_sets();
        run("R2 set 9", 1'b0, la(1, 9), '0, LAT_MISS, 1, 0);
        run("R2 set 10", 1'b0, la(1, 10), '0, LAT_MISS, 1, 0);
        run("R2 set 9 kept", 1'b0, la(1, 9), '0, LAT_HIT, 0, 0);
        run("R2 set 10 kept", 1'b0, la(1, 10), '0, LAT_HIT, 0, 0);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) gold[i] = init_val(ADDR_W'(i));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cold_and_hit();
        t_conflict_swap();
        t_fifo_writeback();
        t_write_miss();
        t_distinct_sets();
        repeat (2) @(negedge clk);
        report();
    end
endmodule